// File: doc/BRIEF.md
# Socket Power Switch Serial Link

This block delivers supply settings for two card sockets to an external dual power switch over a three-wire link: a serial clock, a data line and a latch strobe. The host writes an 8-bit power word. The block then presents that word on the data line one bit at a time, starting with the most significant bit. Each bit is changed only when the serial clock falls, because the switch samples data when the clock rises. After the last bit, the block raises the latch strobe for one serial clock period so that the switch applies the new word.

The serial clock has two possible sources, selected by a control input. It can come from an outside low-rate source on `ext_sclk`, which is synchronized into the system clock domain before use. It can also be made inside the block by dividing the system clock, and in that case the block drives it out on `sclk_out` with `sclk_oe` set. If the host writes while a transfer is running, the new value is parked and sent as soon as the current transfer ends. Only the latest parked value is kept.

During reset the block leaves the latch pin undriven and reads it as a board strap. A low level means a pulldown is fitted, which indicates that an external serial EEPROM is present. That result is held until the next reset.

Top module: `psw_serial_if`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `latch_out` and `sdata` are 0.
- R2: `eeprom_present` takes the inverse of `latch_in` as sampled at the last reset cycle (low strap gives 1). It ignores any later change of `latch_in` until the next reset.
- R3: `latch_oe` is 0 throughout reset and 1 from the first cycle after reset.
- R4: `sclk_oe` follows `clk_internal`. In internal mode, `sclk_out` starts low after reset and toggles every HALF_DIV system cycles.
- R5: `sdata` changes only on a falling serial clock edge. In internal mode this is the same system edge on which `sclk_out` falls. In external mode it is 3 system cycles after `ext_sclk` falls (two-stage synchronizer plus edge detect).
- R6: The word is sent as 8 bits, most significant bit first. Its layout is [7:6] socket B Vcc, [5:4] socket B Vpp, [3:2] socket A Vcc, [1:0] socket A Vpp. The Vcc codes are 00 off, 01 5 V, 10 3.3 V and 11 1.8 V.
- R7: `latch_out` rises on the first serial falling edge after the rising edge that samples the last bit. It falls on the next serial falling edge, so it stays high for exactly one serial period.
- R8: `busy` rises one cycle after a word is accepted for sending. It stays high until the cycle in which `latch_out` falls.
- R9: A write made while a word is waiting or being sent is held and sent after the current transfer. A newer write replaces a held one that has not yet started.
- R10: In external mode the serial edges follow `ext_sclk`, and the block never drives `sclk_out` enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_internal | input | 1 | 1: block generates and drives the serial clock; 0: use ext_sclk |
| wr_en | input | 1 | Host write strobe for the power word |
| wr_data | input | 8 | Power word (layout per R6) |
| ext_sclk | input | 1 | External serial clock (asynchronous) |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| sdata | output | 1 | Serial data to the switch |
| latch_in | input | 1 | Latch pin level, read as strap during reset |
| latch_out | output | 1 | Latch strobe value |
| latch_oe | output | 1 | Output enable for the latch pin |
| busy | output | 1 | Transfer in progress |
| eeprom_present | output | 1 | Strap result: external EEPROM fitted |

## Verification
The bench models the switch side of the link. It shifts `sdata` in on every rising serial clock and compares the last eight bits with the expected word at every latch pulse. A design that reversed the bit order, dropped a bit, or latched one edge early would therefore deliver a wrong word. Writes are issued back to back during a busy transfer. This exposes a design that loses the parked word, sends a stale one in place of the newest, or starts a transfer in the middle of another. External mode is driven with a slow clock so that the synchronizer delay of R5 is checked cycle by cycle. The strap pin is wiggled after reset, which catches a design that keeps sampling it.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int SEL_W     = 2;
    localparam int SOCKETS   = 2;
    localparam int SOCK_W    = 2 * SEL_W;
    localparam int WORD_W    = SOCKETS * SOCK_W;
    localparam int BITCNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [SEL_W-1:0] {
        VCC_OFF  = 2'b00,
        VCC_5V0  = 2'b01,
        VCC_3V3  = 2'b10,
        VCC_1V8  = 2'b11
    } vcc_sel_e;

    typedef struct packed {
        logic [SEL_W-1:0] vcc;
        logic [SEL_W-1:0] vpp;
    } sock_pwr_t;

    typedef struct packed {
        sock_pwr_t sock_b;
        sock_pwr_t sock_a;
    } pwr_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_ARM,
        ST_LATCH
    } shift_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_ev_t;

    function automatic pwr_word_t to_word(input logic [WORD_W-1:0] raw);
        pwr_word_t w;
        w = pwr_word_t'(raw);
        return w;
    endfunction

    function automatic logic word_bit(input pwr_word_t w,
                                      input logic [BITCNT_W-1:0] idx);
        logic [WORD_W-1:0] flat;
        flat = w;
        return flat[WORD_W-1-int'(idx)];
    endfunction

endpackage

// File: rtl/psw_clk_src.sv
module psw_clk_src
    import psw_pkg::*;
#(
    parameter int HALF_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     use_internal,
    input  logic     ext_clk,
    output logic     int_clk,
    output sclk_ev_t ev
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0]     div_q;
    logic                 tick;
    logic [SYNC_STAGES:0] sync_q;
    sclk_ev_t             int_ev;
    sclk_ev_t             ext_ev;

    assign tick = (div_q == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            int_clk <= 1'b0;
        end else if (tick) begin
            div_q   <= '0;
            int_clk <= ~int_clk;
        end else begin
            div_q   <= div_q + 1'b1;
        end
    end

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
            end
        end
    endgenerate

    always_comb begin
        int_ev.rise = tick & ~int_clk;
        int_ev.fall = tick &  int_clk;
        ext_ev.rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
        ext_ev.fall = ~sync_q[SYNC_STAGES-1] &  sync_q[SYNC_STAGES];
        ev = use_internal ? int_ev : ext_ev;
    end

endmodule

// File: rtl/psw_shifter.sv
module psw_shifter
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  sclk_ev_t          ev,
    output logic              sdata,
    output logic              latch,
    output logic              busy
);
    shift_state_e          state_q;
    pwr_word_t             cur_q;
    pwr_word_t             park_q;
    logic                  park_vld_q;
    logic [BITCNT_W-1:0]   cnt_q;
    logic                  start;

    assign start = (state_q == ST_IDLE) && park_vld_q;
    assign busy  = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            park_vld_q <= 1'b0;
            park_q     <= '0;
        end else if (wr_en) begin
            park_vld_q <= 1'b1;
            park_q     <= to_word(wr_data);
        end else if (start) begin
            park_vld_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            sdata   <= 1'b0;
            latch   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (park_vld_q) begin
                        cur_q   <= park_q;
                        cnt_q   <= '0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (ev.fall) begin
                        sdata <= word_bit(cur_q, cnt_q);
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == BITCNT_W'(WORD_W - 1))
                            state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (ev.rise) state_q <= ST_ARM;
                end
                ST_ARM: begin
                    if (ev.fall) begin
                        latch   <= 1'b1;
                        state_q <= ST_LATCH;
                    end
                end
                ST_LATCH: begin
                    if (ev.fall) begin
                        latch   <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psw_strap.sv
module psw_strap (
    input  logic clk,
    input  logic rst,
    input  logic pin_level,
    output logic pin_oe,
    output logic strap_low
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_oe    <= 1'b0;
            strap_low <= ~pin_level;
        end else begin
            pin_oe    <= 1'b1;
        end
    end
endmodule

// File: rtl/psw_serial_if.sv
module psw_serial_if
    import psw_pkg::*;
#(
    parameter int HALF_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_internal,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ext_sclk,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdata,
    input  logic              latch_in,
    output logic              latch_out,
    output logic              latch_oe,
    output logic              busy,
    output logic              eeprom_present
);
    sclk_ev_t ev;

    assign sclk_oe = clk_internal;

    psw_clk_src #(
        .HALF_DIV    (HALF_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clk (
        .clk          (clk),
        .rst          (rst),
        .use_internal (clk_internal),
        .ext_clk      (ext_sclk),
        .int_clk      (sclk_out),
        .ev           (ev)
    );

    psw_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ev      (ev),
        .sdata   (sdata),
        .latch   (latch_out),
        .busy    (busy)
    );

    psw_strap u_strap (
        .clk       (clk),
        .rst       (rst),
        .pin_level (latch_in),
        .pin_oe    (latch_oe),
        .strap_low (eeprom_present)
    );

endmodule

// File: rtl/psw_serial_if_checker.sv
module psw_serial_if_checker (
    input logic clk,
    input logic rst,
    input logic clk_internal,
    input logic sclk_out,
    input logic sdata,
    input logic latch_out,
    input logic latch_oe,
    input logic busy,
    input logic eeprom_present
);
    // R3: pin driven once reset is gone
    a_r3_latch_driven: assert property (@(posedge clk) disable iff (rst)
        !rst |=> latch_oe);

    // R7: strobe only inside a transfer
    a_r7_latch_in_busy: assert property (@(posedge clk) disable iff (rst)
        latch_out |-> busy);

    // R5: data moves only with a falling generated clock
    a_r5_data_on_fall: assert property (@(posedge clk) disable iff (rst)
        (clk_internal && $past(clk_internal) && !$stable(sdata)) |-> $fell(sclk_out));

    // R7: strobe edges coincide with falling generated clock
    a_r7_latch_on_fall: assert property (@(posedge clk) disable iff (rst)
        (clk_internal && $past(clk_internal) && !$stable(latch_out)) |-> $fell(sclk_out));

    // R8: a transfer starts with the strobe low
    a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !latch_out);

    // R2: strap result frozen outside reset
    a_r2_strap_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(!rst)) |-> $stable(eeprom_present));
endmodule

bind psw_serial_if psw_serial_if_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .clk_internal   (clk_internal),
    .sclk_out       (sclk_out),
    .sdata          (sdata),
    .latch_out      (latch_out),
    .latch_oe       (latch_oe),
    .busy           (busy),
    .eeprom_present (eeprom_present)
);

// File: tb/psw_serial_if_test.sv
`timescale 1ns/1ps
module psw_serial_if_test;
    localparam int HALF = 8;

    logic       clk = 0;
    logic       rst = 1;
    logic       clk_internal = 1;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       ext_sclk = 0;
    logic       latch_in = 0;
    logic       sclk_out, sclk_oe, sdata, latch_out, latch_oe, busy, eeprom_present;

    psw_serial_if #(.HALF_DIV(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .clk_internal(clk_internal), .wr_en(wr_en),
        .wr_data(wr_data), .ext_sclk(ext_sclk), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sdata(sdata), .latch_in(latch_in),
        .latch_out(latch_out), .latch_oe(latch_oe), .busy(busy),
        .eeprom_present(eeprom_present)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit ext_run = 0;
    bit done = 0;
    int cyc = 0;

    // reference model state
    int m_div, m_st, m_cnt, m_pend, m_cur;
    bit m_sclk, m_sdata, m_latch, m_eep, m_loe;
    bit e0, e1, e2;
    int exp_q[$];
    logic [7:0] sw_reg = 0;
    bit prev_line = 0, prev_latch = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model: 0 idle,1 shift,2 hold,3 arm,4 latch
    always @(posedge clk) begin
        bit irise, ifall, erise, efall, rise, fall;
        if (rst) begin
            m_div = 0; m_sclk = 0; m_st = 0; m_cnt = 0; m_pend = -1;
            m_sdata = 0; m_latch = 0; m_loe = 0; m_eep = !latch_in;
            e0 = 0; e1 = 0; e2 = 0;
        end else begin
            m_loe = 1;
            irise = (m_div == HALF-1) && !m_sclk;
            ifall = (m_div == HALF-1) &&  m_sclk;
            erise = e1 && !e2;
            efall = !e1 && e2;
            rise  = clk_internal ? irise : erise;
            fall  = clk_internal ? ifall : efall;
            if (m_div == HALF-1) begin m_div = 0; m_sclk = !m_sclk; end
            else m_div++;
            e2 = e1; e1 = e0; e0 = ext_sclk;
            case (m_st)
                0: if (m_pend >= 0) begin m_cur = m_pend; m_pend = -1; m_cnt = 0; m_st = 1; end
                1: if (fall) begin
                       m_sdata = m_cur[7-m_cnt]; m_cnt++;
                       if (m_cnt == 8) m_st = 2;
                   end
                2: if (rise) m_st = 3;
                3: if (fall) begin m_latch = 1; m_st = 4; end
                default: if (fall) begin m_latch = 0; m_st = 0; end
            endcase
            if (wr_en) m_pend = wr_data;
        end
    end

    // per-cycle comparison and switch-side capture
    always @(negedge clk) begin
        bit line;
        cyc++;
        chk("R8 busy", busy, m_st != 0);
        chk("R7 latch_out", latch_out, m_latch);
        chk("R5/R6 sdata", sdata, m_sdata);
        chk("R3 latch_oe", latch_oe, m_loe);
        chk("R2 eeprom_present", eeprom_present, m_eep);
        chk("R4/R10 sclk_oe", sclk_oe, clk_internal);
        if (clk_internal) chk("R4 sclk_out", sclk_out, m_sclk);
        line = sclk_oe ? sclk_out : ext_sclk;
        if (!rst && line && !prev_line) sw_reg = {sw_reg[6:0], sdata};
        if (!rst && latch_out && !prev_latch) begin
            if (exp_q.size() == 0) chk("R9 unexpected latch", 1, 0);
            else chk("R6/R9 word at switch", sw_reg, exp_q.pop_front());
        end
        prev_line = line;
        prev_latch = latch_out;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        forever begin
            repeat (20) @(negedge clk);
            #1 if (ext_run) ext_sclk = ~ext_sclk;
        end
    end

    task automatic put(input logic [7:0] v);
        @(negedge clk); #1 wr_en = 1; wr_data = v;
        @(negedge clk); #1 wr_en = 0;
    endtask

    task automatic wait_idle();
        while (m_pend >= 0 || m_st != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // phase 1: internal clock, pulldown strap
        latch_in = 0; rst = 1; clk_internal = 1;
        repeat (5) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 latch in reset", latch_out, 0);
        chk("R3 latch_oe in reset", latch_oe, 0);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 sdata after reset", sdata, 0);
        chk("R2 strap low seen", eeprom_present, 1);
        latch_in = 1;                        // R2: must be ignored
        repeat (10) @(negedge clk);
        chk("R2 strap ignored", eeprom_present, 1);
        exp_q.push_back(8'hA5);               // R6: socket B 10/10, socket A 01/01
        put(8'hA5);
        wait_idle();
        exp_q.push_back(8'h3C);
        exp_q.push_back(8'h72);               // R9: 8'h11 replaced by 8'h72
        put(8'h3C);
        repeat (30) @(negedge clk);
        put(8'h11);
        repeat (5) @(negedge clk);
        put(8'h72);
        wait_idle();
        exp_q.push_back(8'hFF);
        exp_q.push_back(8'h00);
        put(8'hFF); put(8'h00);               // R9 back-to-back
        wait_idle();

        // phase 2: external clock, strap high
        #1 rst = 1; latch_in = 1; clk_internal = 0;
        repeat (4) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R2 strap high seen", eeprom_present, 0);
        chk("R10 clock not driven", sclk_oe, 0);
        ext_run = 1;
        exp_q.push_back(8'hC3);
        put(8'hC3);
        wait_idle();
        exp_q.push_back(8'h96);
        exp_q.push_back(8'h01);
        put(8'h96);
        repeat (50) @(negedge clk);
        put(8'h01);
        wait_idle();
        chk("R9 all words delivered", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule